// File: doc/BRIEF.md
# SDRAM Power-Mode Command Sequencer

This block sits between a control-register write port and the command path of an SDRAM controller. It sequences the device into and out of self-refresh, and it holds a software trigger for the power-up (initialization) sequence until the next memory access arrives. Ordinary read/write timing, the auto-refresh counter and the contents of the initialization sequence live elsewhere. Initialization completion comes back through a single done pulse.

Software writes a one to a trigger bit to request self-refresh. The block lets every pending access drain, goes idle, and precharges all banks only if a bank is open. It then enters self-refresh and raises a status bit. Entry cannot be called back. The device leaves self-refresh only when the host presents a new access. The block then issues the exit command and waits a programmable number of cycles before it grants accesses again. The power-up bit only arms a request, and initialization starts when the next access shows up.

Commands leave on a valid/ready channel. Once `cmd_valid` is high, it stays high and `cmd_code` stays unchanged until `cmd_ready` is seen high at a clock edge. That edge is the single transfer cycle. The block never withdraws a command it has offered.

Top module: `sdram_pwr_seq`

## Requirements
- R1: After synchronous reset, `acc_grant` is 1, `sr_active` is 0, `cmd_valid` is 0, `cfg_rdata` is 0, and no request is armed.
- R2: A write with bit 0 set requests self-refresh entry. A write with bit 0 clear starts nothing. Bit 1 clear also arms no power-up, and `acc_grant` stays 1.
- R3: In `cfg_rdata`, bits 0 and 1 always read 0, and bit 2 reads the value of `sr_active`. All other bits read 0.
- R4: While `acc_pend` is high after a self-refresh request, `acc_grant` stays 1 and no precharge or entry command is offered.
- R5: Once pending accesses have drained, a precharge-all command (code 0) is offered before the entry command (code 1) only if `bank_open` is high. Otherwise the entry command comes directly.
- R6: `sr_active` rises in the cycle after the entry command transfers. While it is high, `acc_grant` is 0.
- R7: Writes to bit 0 while `sr_active` is high are ignored. They arm nothing and are not served after exit.
- R8: In self-refresh, only `acc_pend` high causes the exit command (code 2). After that command transfers, `sr_active` stays high for `exit_wait`+1 cycles and then clears. `acc_grant` rises in the same cycle that `sr_active` clears.
- R9: A write with bit 1 set arms power-up and drops `acc_grant`. The initialization command (code 3) is offered only once `acc_pend` is high. `acc_grant` returns to 1 after the `init_done` pulse.
- R10: A power-up request armed during self-refresh causes no command until the exit completes. The initialization command follows the exit.
- R11: A command that is offered keeps `cmd_valid` high and `cmd_code` stable until `cmd_ready` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | REG_W | Write data: bit 0 self-refresh trigger, bit 1 power-up trigger |
| cfg_rdata | output | REG_W | Read data: bit 2 self-refresh status, trigger bits read 0 |
| exit_wait | input | CNT_W | Cycles to wait after exit command, minus one |
| acc_pend | input | 1 | Host has a memory access pending |
| bank_open | input | 1 | At least one SDRAM bank is open |
| acc_grant | output | 1 | Normal accesses may proceed |
| cmd_valid | output | 1 | Command offered |
| cmd_code | output | 2 | 0 precharge-all, 1 self-refresh entry, 2 self-refresh exit, 3 start initialization |
| cmd_ready | input | 1 | Command path accepts the offered command |
| init_done | input | 1 | Initialization sequence finished (pulse) |
| sr_active | output | 1 | Device is in self-refresh |

## Verification
Some properties are checked on every cycle by assertions:
- the offered command holds steady under back-pressure;
- grant and self-refresh status are never high together;
- the trigger bits read zero and the status bit matches `sr_active`;
- precharge and entry are offered only with the grant low;
- exit is offered only while self-refresh is active.

Other behaviour needs ordered stimulus and only the bench's scenarios can show it:
- draining while accesses remain pending;
- the choice of precharge depending on the bank state;
- the exact exit wait for different `exit_wait` values;
- ignored triggers while in self-refresh;
- a power-up that is deferred across an exit.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
  typedef enum logic [3:0] {
    ST_NORM, ST_DRAIN, ST_PRE, ST_ENTER, ST_SREF,
    ST_XCMD, ST_XWAIT, ST_ICMD, ST_IWAIT
  } pwr_state_t;

  typedef enum logic [1:0] {
    CMD_PRECH = 2'd0,
    CMD_SR_IN = 2'd1,
    CMD_SR_OUT = 2'd2,
    CMD_INIT = 2'd3
  } pwr_cmd_t;
endpackage

// File: rtl/pwr_req_latch.sv
module pwr_req_latch #(
  parameter int REG_W = 8,
  parameter int SR_BIT = 0,
  parameter int PU_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             in_sr,
  input  logic             sr_taken,
  input  logic             pu_taken,
  output logic             sr_req,
  output logic             pu_armed
);
  logic sr_hit, pu_hit;

  assign sr_hit = cfg_we && cfg_wdata[SR_BIT] && !in_sr;
  assign pu_hit = cfg_we && cfg_wdata[PU_BIT];

  // self-refresh: consumption wins so a trigger racing entry is not replayed
  always_ff @(posedge clk) begin
    if (rst) sr_req <= 1'b0;
    else if (sr_taken) sr_req <= 1'b0;
    else if (sr_hit) sr_req <= 1'b1;
  end

  // power-up: a fresh trigger wins over consumption
  always_ff @(posedge clk) begin
    if (rst) pu_armed <= 1'b0;
    else if (pu_hit) pu_armed <= 1'b1;
    else if (pu_taken) pu_armed <= 1'b0;
  end
endmodule

// File: rtl/pwr_wait_cnt.sv
module pwr_wait_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import sdram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sr_req,
  input  logic       pu_armed,
  input  logic       acc_pend,
  input  logic       bank_open,
  input  logic       cmd_ready,
  input  logic       init_done,
  input  logic       cnt_zero,
  output logic       cmd_valid,
  output logic [1:0] cmd_code,
  output logic       acc_grant,
  output logic       sr_active,
  output logic       sr_taken,
  output logic       pu_taken,
  output logic       cnt_load
);
  pwr_state_t st, nxt;
  pwr_cmd_t   code;
  logic       pu_go;

  assign pu_go = pu_armed && acc_pend;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_NORM;
    else st <= nxt;
  end

  always_comb begin
    nxt       = st;
    cmd_valid = 1'b0;
    code      = CMD_PRECH;
    sr_taken  = 1'b0;
    pu_taken  = 1'b0;
    cnt_load  = 1'b0;
    unique case (st)
      ST_NORM: begin
        if (pu_go) nxt = ST_ICMD;
        else if (sr_req) nxt = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (pu_go) nxt = ST_ICMD;
        else if (!acc_pend) nxt = bank_open ? ST_PRE : ST_ENTER;
      end
      ST_PRE: begin
        cmd_valid = 1'b1;
        code      = CMD_PRECH;
        if (cmd_ready) nxt = ST_ENTER;
      end
      ST_ENTER: begin
        cmd_valid = 1'b1;
        code      = CMD_SR_IN;
        if (cmd_ready) begin
          nxt      = ST_SREF;
          sr_taken = 1'b1;
        end
      end
      ST_SREF: begin
        if (acc_pend) nxt = ST_XCMD;
      end
      ST_XCMD: begin
        cmd_valid = 1'b1;
        code      = CMD_SR_OUT;
        if (cmd_ready) begin
          nxt      = ST_XWAIT;
          cnt_load = 1'b1;
        end
      end
      ST_XWAIT: begin
        if (cnt_zero) nxt = ST_NORM;
      end
      ST_ICMD: begin
        cmd_valid = 1'b1;
        code      = CMD_INIT;
        if (cmd_ready) begin
          nxt      = ST_IWAIT;
          pu_taken = 1'b1;
        end
      end
      ST_IWAIT: begin
        if (init_done) nxt = ST_NORM;
      end
      default: nxt = ST_NORM;
    endcase
  end

  assign cmd_code  = code;
  assign sr_active = (st == ST_SREF) || (st == ST_XCMD) || (st == ST_XWAIT);
  assign acc_grant = ((st == ST_NORM) || (st == ST_DRAIN)) && !pu_armed;
endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq #(
  parameter int REG_W    = 8,
  parameter int SR_BIT   = 0,
  parameter int PU_BIT   = 1,
  parameter int STAT_BIT = 2,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [CNT_W-1:0] exit_wait,
  input  logic             acc_pend,
  input  logic             bank_open,
  output logic             acc_grant,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code,
  input  logic             cmd_ready,
  input  logic             init_done,
  output logic             sr_active
);
  logic sr_req, pu_armed, sr_taken, pu_taken, cnt_load, cnt_zero;

  pwr_req_latch #(.REG_W(REG_W), .SR_BIT(SR_BIT), .PU_BIT(PU_BIT)) u_req (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_sr(sr_active), .sr_taken(sr_taken), .pu_taken(pu_taken),
    .sr_req(sr_req), .pu_armed(pu_armed)
  );

  pwr_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(exit_wait), .zero(cnt_zero)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .sr_req(sr_req), .pu_armed(pu_armed),
    .acc_pend(acc_pend), .bank_open(bank_open), .cmd_ready(cmd_ready),
    .init_done(init_done), .cnt_zero(cnt_zero), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .acc_grant(acc_grant), .sr_active(sr_active),
    .sr_taken(sr_taken), .pu_taken(pu_taken), .cnt_load(cnt_load)
  );

  // trigger bits are write-only: only the status bit is visible
  always_comb begin
    cfg_rdata           = '0;
    cfg_rdata[STAT_BIT] = sr_active;
  end
endmodule

// File: rtl/sdram_pwr_seq_chk.sv
module sdram_pwr_seq_chk #(
  parameter int REG_W    = 8,
  parameter int SR_BIT   = 0,
  parameter int PU_BIT   = 1,
  parameter int STAT_BIT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             acc_grant,
  input logic             cmd_valid,
  input logic [1:0]       cmd_code,
  input logic             cmd_ready,
  input logic             sr_active
);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code)));

  // R6
  grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_grant && sr_active));

  // R6
  enter_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_code == 2'd1) |=> sr_active);

  // R3
  rdata_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[SR_BIT] == 1'b0) && (cfg_rdata[PU_BIT] == 1'b0) &&
    (cfg_rdata[STAT_BIT] == sr_active));

  // R4
  entry_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == 2'd0 || cmd_code == 2'd1)) |-> (!acc_grant && !sr_active));

  // R8
  exit_in_sr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'd2) |-> sr_active);
endmodule

bind sdram_pwr_seq sdram_pwr_seq_chk #(
  .REG_W(REG_W), .SR_BIT(SR_BIT), .PU_BIT(PU_BIT), .STAT_BIT(STAT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .acc_grant(acc_grant),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
  .sr_active(sr_active)
);

// File: tb/test_sdram_pwr_seq.sv
module test_sdram_pwr_seq;
  localparam int REG_W = 8;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [REG_W-1:0] cfg_wdata = '0;
  logic [REG_W-1:0] cfg_rdata;
  logic [CNT_W-1:0] exit_wait = '0;
  logic             acc_pend = 1'b0;
  logic             bank_open = 1'b0;
  logic             acc_grant;
  logic             cmd_valid;
  logic [1:0]       cmd_code;
  logic             cmd_ready = 1'b0;
  logic             init_done = 1'b0;
  logic             sr_active;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  sdram_pwr_seq i_sdram_pwr_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .exit_wait(exit_wait), .acc_pend(acc_pend),
    .bank_open(bank_open), .acc_grant(acc_grant), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_ready(cmd_ready), .init_done(init_done),
    .sr_active(sr_active)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=20000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  // waits for an offered command at a negedge and checks its code
  task automatic wait_cmd(input string req, input int code);
    int n = 0;
    while (!cmd_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk({req, " cmd offered"}, int'(cmd_valid), 1);
    chk({req, " cmd code"}, int'(cmd_code), code);
  endtask

  task automatic accept();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic quiet(input string req, input int n, input int exp_grant);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({req, " no cmd"}, int'(cmd_valid), 0);
      chk({req, " grant"}, int'(acc_grant), exp_grant);
    end
  endtask

  // writes that leave bit 0 and bit 1 clear: no effect, read-back zero
  localparam logic [REG_W-1:0] WR_VEC [6] = '{8'h00, 8'h04, 8'h80, 8'hFC, 8'h7C, 8'h08};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 grant", int'(acc_grant), 1);
    chk("R1 sr_active", int'(sr_active), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 rdata", int'(cfg_rdata), 0);

    // R2 / R3 vector walk
    foreach (WR_VEC[k]) begin
      wr(WR_VEC[k]);
      repeat (2) @(negedge clk);
      chk("R2 no cmd after zero-trigger write", int'(cmd_valid), 0);
      chk("R2 grant kept", int'(acc_grant), 1);
      chk("R3 rdata zero", int'(cfg_rdata), 0);
    end

    // R5 bank closed: entry directly; R11 hold under back-pressure
    wr(8'h01);
    wait_cmd("R5 closed bank entry", 1);
    repeat (3) begin
      @(negedge clk);
      chk("R11 valid held", int'(cmd_valid), 1);
      chk("R11 code stable", int'(cmd_code), 1);
    end
    accept();
    chk("R6 sr_active set", int'(sr_active), 1);
    chk("R6 grant low", int'(acc_grant), 0);
    chk("R3 status bit", int'(cfg_rdata), 4);

    // R7 trigger while active is ignored
    wr(8'h01);
    quiet("R7 in self-refresh", 4, 0);

    // R8 exit with wait of 3
    exit_wait = 8'd3;
    acc_pend = 1'b1;
    wait_cmd("R8 exit", 2);
    accept();
    chk("R8 active after accept", int'(sr_active), 1);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      chk("R8 active during wait", int'(sr_active), 1);
      chk("R8 grant low during wait", int'(acc_grant), 0);
    end
    @(negedge clk);
    chk("R8 active cleared", int'(sr_active), 0);
    chk("R8 grant back", int'(acc_grant), 1);
    acc_pend = 1'b0;
    quiet("R7 ignored trigger not replayed", 6, 1);

    // R4 drain then R5 precharge with open bank
    acc_pend = 1'b1;
    bank_open = 1'b1;
    wr(8'h01);
    quiet("R4 draining", 6, 1);
    acc_pend = 1'b0;
    wait_cmd("R5 open bank precharge", 0);
    accept();
    wait_cmd("R5 entry after precharge", 1);
    accept();
    bank_open = 1'b0;
    chk("R6 sr_active after precharge path", int'(sr_active), 1);

    // R8 exit with zero wait
    exit_wait = 8'd0;
    quiet("R8 no exit without access", 3, 0);
    acc_pend = 1'b1;
    wait_cmd("R8 exit zero wait", 2);
    accept();
    chk("R8 zero wait still active", int'(sr_active), 1);
    @(negedge clk);
    chk("R8 zero wait cleared", int'(sr_active), 0);
    chk("R8 zero wait grant", int'(acc_grant), 1);
    acc_pend = 1'b0;

    // R9 power-up armed, starts on next access
    wr(8'h02);
    chk("R9 grant dropped when armed", int'(acc_grant), 0);
    quiet("R9 armed idle", 4, 0);
    acc_pend = 1'b1;
    wait_cmd("R9 init start", 3);
    accept();
    quiet("R9 awaiting done", 3, 0);
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    chk("R9 grant after done", int'(acc_grant), 1);
    acc_pend = 1'b0;

    // R10 power-up armed in self-refresh
    wr(8'h01);
    wait_cmd("R10 entry", 1);
    accept();
    wr(8'h02);
    quiet("R10 deferred in self-refresh", 4, 0);
    exit_wait = 8'd2;
    acc_pend = 1'b1;
    wait_cmd("R10 exit first", 2);
    accept();
    for (int i = 2; i <= 3; i++) @(negedge clk);
    chk("R10 still active in wait", int'(sr_active), 1);
    @(negedge clk);
    chk("R10 exit done", int'(sr_active), 0);
    chk("R10 grant held for init", int'(acc_grant), 0);
    wait_cmd("R10 init after exit", 3);
    accept();
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    chk("R10 grant after init", int'(acc_grant), 1);
    acc_pend = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule